// File: doc/BRIEF.md
# Interleaved IQ Transmit Input Assembler

This block takes a stream of 12-bit transmit words from a baseband bus, where in-phase (I) and quadrature (Q) samples alternate on the same wires. It tells them apart, joins each I/Q couple into one pair and carries the pairs across an eight-entry asynchronous FIFO into the converter clock domain. On the converter side the pairs come out on two parallel 12-bit outputs, at most one pair every R converter clocks, where R is the interpolation ratio (1, 2, 4 or 8). A one-cycle strobe marks each new pair.

Words and their channel qualifier are registered on the rising edge of the interface clock. The channel of a word comes from the qualifier, whose active level can be inverted. In the double-rate mode the channel comes instead from a clock-phase flag, and the qualifier is ignored. Configuration bits select which channel leads a pair and whether the input words are offset binary or two's complement. The outputs are always two's complement.

The pairing logic is a two-state machine. ASM_IDLE goes to ASM_HELD when a leading-channel word arrives. ASM_HELD returns to ASM_IDLE when a trailing-channel word completes the pair. In ASM_HELD a further leading word replaces the held one. The read pacer is also a two-state machine. PACE_PRIME goes to PACE_STREAM once the FIFO holds half its depth, and PACE_STREAM stays there until reset. Two sticky flags record a pair lost to a full FIFO and a delivery slot that found the FIFO empty.

Top module: `txq_pair_assembler`

## Requirements
- R1: Word, enable and qualifier are registered on the rising edge of wr_clk. With cfg_ddr=0 a word is I when bus_sel equals 1 and cfg_i_low=0, or when bus_sel equals 0 and cfg_i_low=1; otherwise it is Q.
- R2: With cfg_q_first=0 I leads a pair, and with cfg_q_first=1 Q leads. A pair forms when a trailing-channel word follows a held leading word. A repeated leading word replaces the held one. A trailing word with nothing held is dropped.
- R3: With cfg_twos=1 words pass unchanged. With cfg_twos=0 they are offset binary and bit 11 is inverted. out_i and out_q are two's complement.
- R4: With cfg_ddr=1 the channel is taken from ddr_phase (1 = I, 0 = Q) and bus_sel has no effect.
- R5: cfg_ratio values 0, 1, 2 and 3 give R = 1, 2, 4 and 8. Pairs leave in arrival order, at most one per R rd_clk cycles, and out_stb is high for exactly one rd_clk cycle per new pair. out_i and out_q hold their value between strobes.
- R6: Pairs are stored in an 8-entry FIFO whose write pointer changes by at most one Gray-code bit per wr_clk cycle. The FIFO delivers back-to-back pairs at exactly R cycles apart while it holds data.
- R7: A pair completed while the FIFO is full is dropped and sets the sticky overflow flag. The flag stays set until rst_n goes low.
- R8: Once streaming, a delivery slot that finds the FIFO empty sets the sticky underflow flag. The flag stays set until rst_n goes low.
- R9: After reset no pair is delivered, and underflow stays 0, until the FIFO holds at least 4 pairs.
- R10: While and right after reset, out_i, out_q, out_stb, overflow and underflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Interface clock, data captured on rising edge |
| rd_clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_en | input | 1 | Word present on the bus this cycle |
| bus_word | input | 12 | Interleaved transmit word |
| bus_sel | input | 1 | I/Q qualifier |
| ddr_phase | input | 1 | Clock-phase flag used as channel in double-rate mode |
| cfg_q_first | input | 1 | 1: Q leads each pair |
| cfg_i_low | input | 1 | 1: I words coincide with qualifier low |
| cfg_twos | input | 1 | 1: input words are two's complement |
| cfg_ddr | input | 1 | 1: double-rate mode, channel from ddr_phase |
| cfg_ratio | input | 2 | Interpolation ratio code (R = 2^code) |
| out_i | output | 12 | In-phase output sample |
| out_q | output | 12 | Quadrature output sample |
| out_stb | output | 1 | One-cycle marker of a new pair |
| overflow | output | 1 | Sticky: pair dropped on full FIFO |
| underflow | output | 1 | Sticky: delivery slot found FIFO empty |

## Verification
Two functions can fall in the same cycle here: a pair completing on the write side while the FIFO is full, and the read side freeing a slot. The freed slot becomes visible to the writer only after the pointer synchronizer, so the pair is dropped. The bench provokes this by feeding twenty back-to-back pairs at the slowest read ratio, so that drops and reads overlap. It then judges that overflow is set, that fewer pairs arrive than were sent, and that those that arrive form an in-order subsequence of what was sent.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic {
        ASM_IDLE,
        ASM_HELD
    } asm_state_e;

    typedef enum logic {
        PACE_PRIME,
        PACE_STREAM
    } pace_state_e;

endpackage

// File: rtl/txq_capture.sv
module txq_capture
    import txq_pkg::*;
#(
    parameter int W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic [W-1:0]   bus_word,
    input  logic           bus_sel,
    input  logic           ddr_phase,
    input  logic           cfg_q_first,
    input  logic           cfg_i_low,
    input  logic           cfg_twos,
    input  logic           cfg_ddr,
    output logic           push,
    output logic [2*W-1:0] push_pair
);

    logic         cap_en;
    logic [W-1:0] cap_word;
    logic         cap_sel;
    logic         cap_ph;

    // input latch on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_en   <= 1'b0;
            cap_word <= '0;
            cap_sel  <= 1'b0;
            cap_ph   <= 1'b0;
        end else begin
            cap_en   <= bus_en;
            cap_word <= bus_word;
            cap_sel  <= bus_sel;
            cap_ph   <= ddr_phase;
        end
    end

    logic         word_is_i;
    logic         word_leads;
    logic [W-1:0] word_fmt;

    always_comb begin
        word_is_i  = cfg_ddr ? cap_ph : (cap_sel ^ cfg_i_low);
        word_leads = (word_is_i == !cfg_q_first);
        word_fmt   = cfg_twos ? cap_word : {~cap_word[W-1], cap_word[W-2:0]};
    end

    asm_state_e   state, state_nx;
    logic [W-1:0] held;
    logic         load_held;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ASM_IDLE;
            held  <= '0;
        end else begin
            state <= state_nx;
            if (load_held) begin
                held <= word_fmt;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        load_held = 1'b0;
        push      = 1'b0;
        push_pair = cfg_q_first ? {word_fmt, held} : {held, word_fmt};
        unique case (state)
            ASM_IDLE: begin
                if (cap_en && word_leads) begin
                    load_held = 1'b1;
                    state_nx  = ASM_HELD;
                end
            end
            ASM_HELD: begin
                if (cap_en && word_leads) begin
                    load_held = 1'b1;
                end else if (cap_en) begin
                    push     = 1'b1;
                    state_nx = ASM_IDLE;
                end
            end
            default: state_nx = ASM_IDLE;
        endcase
    end

endmodule

// File: rtl/txq_async_fifo.sv
module txq_async_fifo #(
    parameter int DW    = 24,
    parameter int DEPTH = 8,
    parameter int SYNC  = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic [AW:0]   rd_level,
    output logic          overflow,
    output logic [AW:0]   wr_gray_o
);

    function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int k = AW - 1; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];

    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] r2w [SYNC];
    logic [AW:0] w2r [SYNC];
    logic        full;

    // synchronizer chains, one per direction
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC; s++) r2w[s] <= '0;
        end else begin
            r2w[0] <= rgray;
            for (int s = 1; s < SYNC; s++) r2w[s] <= r2w[s-1];
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC; s++) w2r[s] <= '0;
        end else begin
            w2r[0] <= wgray;
            for (int s = 1; s < SYNC; s++) w2r[s] <= w2r[s-1];
        end
    end

    // write side
    assign full = (wgray == {~r2w[SYNC-1][AW:AW-1], r2w[SYNC-1][AW-2:0]});

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_en && !full) begin
                wbin  <= wbin + 1'b1;
                wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
            end
            if (wr_en && full) begin
                overflow <= 1'b1;
            end
        end
    end

    // read side
    assign empty    = (rgray == w2r[SYNC-1]);
    assign rd_level = gray_to_bin(w2r[SYNC-1]) - rbin;
    assign rd_data  = mem[rbin[AW-1:0]];

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en && !empty) begin
            rbin  <= rbin + 1'b1;
            rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        end
    end

    assign wr_gray_o = wgray;

endmodule

// File: rtl/txq_read_pacer.sv
module txq_read_pacer
    import txq_pkg::*;
#(
    parameter int DW    = 24,
    parameter int LW    = 4,
    parameter int PRIME = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_ratio,
    input  logic          empty,
    input  logic [LW-1:0] level,
    input  logic [DW-1:0] rd_data,
    output logic          rd_en,
    output logic [DW-1:0] out_pair,
    output logic          out_stb,
    output logic          underflow,
    output logic          tick
);

    logic [CW-1:0] cnt;
    logic [CW:0]   lim;

    // rate divider: one delivery slot every 2^cfg_ratio clocks
    always_comb begin
        lim  = ({{CW{1'b0}}, 1'b1} << cfg_ratio) - 1'b1;
        tick = ({1'b0, cnt} >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    pace_state_e state, state_nx;
    logic        slot_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PACE_PRIME;
        end else begin
            state <= state_nx;
        end
    end

    // next state and read strobe
    always_comb begin
        state_nx   = state;
        rd_en      = 1'b0;
        slot_empty = 1'b0;
        unique case (state)
            PACE_PRIME: begin
                if (level >= LW'(PRIME)) state_nx = PACE_STREAM;
            end
            PACE_STREAM: begin
                rd_en      = tick && !empty;
                slot_empty = tick && empty;
            end
            default: state_nx = PACE_PRIME;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pair  <= '0;
            out_stb   <= 1'b0;
            underflow <= 1'b0;
        end else begin
            out_stb <= rd_en;
            if (rd_en) begin
                out_pair <= rd_data;
            end
            if (slot_empty) begin
                underflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txq_pair_assembler.sv
module txq_pair_assembler #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    parameter int SYNC  = 2,
    parameter int MAX_R = 8
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         bus_en,
    input  logic [W-1:0] bus_word,
    input  logic         bus_sel,
    input  logic         ddr_phase,
    input  logic         cfg_q_first,
    input  logic         cfg_i_low,
    input  logic         cfg_twos,
    input  logic         cfg_ddr,
    input  logic [1:0]   cfg_ratio,
    output logic [W-1:0] out_i,
    output logic [W-1:0] out_q,
    output logic         out_stb,
    output logic         overflow,
    output logic         underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(MAX_R);

    logic          push;
    logic [DW-1:0] push_pair;
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic          empty;
    logic [AW:0]   rd_level;
    logic [AW:0]   wr_gray;
    logic [DW-1:0] out_pair;
    logic          rate_tick;

    txq_capture #(.W(W)) u_cap (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_word   (bus_word),
        .bus_sel    (bus_sel),
        .ddr_phase  (ddr_phase),
        .cfg_q_first(cfg_q_first),
        .cfg_i_low  (cfg_i_low),
        .cfg_twos   (cfg_twos),
        .cfg_ddr    (cfg_ddr),
        .push       (push),
        .push_pair  (push_pair)
    );

    txq_async_fifo #(.DW(DW), .DEPTH(DEPTH), .SYNC(SYNC)) u_fifo (
        .wr_clk   (wr_clk),
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (push_pair),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty    (empty),
        .rd_level (rd_level),
        .overflow (overflow),
        .wr_gray_o(wr_gray)
    );

    txq_read_pacer #(.DW(DW), .LW(AW + 1), .PRIME(DEPTH / 2), .CW(CW)) u_pace (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .cfg_ratio(cfg_ratio),
        .empty    (empty),
        .level    (rd_level),
        .rd_data  (rd_data),
        .rd_en    (rd_en),
        .out_pair (out_pair),
        .out_stb  (out_stb),
        .underflow(underflow),
        .tick     (rate_tick)
    );

    assign out_i = out_pair[DW-1:W];
    assign out_q = out_pair[W-1:0];

endmodule

// File: rtl/txq_pair_checker.sv
module txq_pair_checker #(
    parameter int W  = 12,
    parameter int AW = 3
) (
    input logic         wr_clk,
    input logic         rd_clk,
    input logic         rst_n,
    input logic [W-1:0] out_i,
    input logic [W-1:0] out_q,
    input logic         out_stb,
    input logic         overflow,
    input logic         underflow,
    input logic [AW:0]  wr_gray,
    input logic         rate_tick
);

    // R6: write pointer crosses domains with a single-bit step
    assert_gray_step_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R7: overflow is sticky
    assert_overflow_sticky_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: underflow is sticky
    assert_underflow_sticky_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R5: a delivery only follows a rate slot
    assert_stb_on_slot_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        out_stb |-> $past(rate_tick));

    // R5: outputs hold between strobes
    assert_out_hold_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_stb |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind txq_pair_assembler txq_pair_checker #(.W(W), .AW(AW)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .out_i    (out_i),
    .out_q    (out_q),
    .out_stb  (out_stb),
    .overflow (overflow),
    .underflow(underflow),
    .wr_gray  (wr_gray),
    .rate_tick(rate_tick)
);

// File: tb/sim_txq_pair_assembler.sv
`timescale 1ns/1ps
module sim_txq_pair_assembler;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        bus_en = 1'b0;
    logic [11:0] bus_word = '0;
    logic        bus_sel = 1'b0;
    logic        ddr_phase = 1'b0;
    logic        cfg_q_first = 1'b0;
    logic        cfg_i_low = 1'b0;
    logic        cfg_twos = 1'b1;
    logic        cfg_ddr = 1'b0;
    logic [1:0]  cfg_ratio = 2'd0;
    logic [11:0] out_i, out_q;
    logic        out_stb, overflow, underflow;

    always #2.0 rd_clk = ~rd_clk;   // 250 MHz
    always #3.5 wr_clk = ~wr_clk;

    txq_pair_assembler u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_word(bus_word), .bus_sel(bus_sel),
        .ddr_phase(ddr_phase), .cfg_q_first(cfg_q_first), .cfg_i_low(cfg_i_low),
        .cfg_twos(cfg_twos), .cfg_ddr(cfg_ddr), .cfg_ratio(cfg_ratio),
        .out_i(out_i), .out_q(out_q), .out_stb(out_stb),
        .overflow(overflow), .underflow(underflow)
    );

    // stimulus table: {q_first, i_low, twos, ddr, ratio[1:0]}
    localparam logic [5:0] MODES [6] = '{6'b001000, 6'b100001, 6'b011010,
                                         6'b110011, 6'b001101, 6'b100110};
    // expected spacing of the first back-to-back deliveries
    localparam int GAPS [6] = '{1, 2, 4, 8, 2, 4};

    int n_chk = 0;
    int n_bad = 0;
    int exp_n = 0;
    logic [11:0] exp_i [32];
    logic [11:0] exp_q [32];
    int rcv_n = 0;
    logic [11:0] rcv_i [32];
    logic [11:0] rcv_q [32];
    int gap [32];
    int rd_cyc = 0;
    int last_cyc = 0;
    logic junk = 1'b0;
    int wd = 0;

    always @(negedge rd_clk) begin
        if (rst_n) begin
            rd_cyc = rd_cyc + 1;
            if (out_stb && rcv_n < 32) begin
                rcv_i[rcv_n] = out_i;
                rcv_q[rcv_n] = out_q;
                gap[rcv_n]   = rd_cyc - last_cyc;
                last_cyc     = rd_cyc;
                rcv_n        = rcv_n + 1;
            end
        end
    end

    always @(posedge rd_clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n  = 1'b0;
        bus_en = 1'b0;
        repeat (4) @(negedge rd_clk);
        rcv_n = 0; exp_n = 0; rd_cyc = 0; last_cyc = 0;
        @(negedge rd_clk);
        #0.3 rst_n = 1'b1;
    endtask

    function automatic logic [11:0] fmt(input logic [11:0] w);
        return cfg_twos ? w : (w ^ 12'h800);
    endfunction

    task automatic send_word(input logic [11:0] w, input logic is_i);
        @(negedge wr_clk);
        bus_en   = 1'b1;
        bus_word = w;
        junk     = ~junk;
        if (cfg_ddr) begin
            ddr_phase = is_i;
            bus_sel   = junk;
        end else begin
            bus_sel   = is_i ^ cfg_i_low;
            ddr_phase = junk;
        end
    endtask

    task automatic idle_bus();
        @(negedge wr_clk);
        bus_en = 1'b0;
    endtask

    task automatic send_pair(input logic [11:0] wi, input logic [11:0] wq);
        if (cfg_q_first) begin
            send_word(wq, 1'b0);
            send_word(wi, 1'b1);
        end else begin
            send_word(wi, 1'b1);
            send_word(wq, 1'b0);
        end
        exp_i[exp_n] = fmt(wi);
        exp_q[exp_n] = fmt(wq);
        exp_n = exp_n + 1;
    endtask

    task automatic compare_all(input string tag);
        check(rcv_n == exp_n, {tag, " pair count"}, rcv_n, exp_n);
        for (int k = 0; k < exp_n && k < rcv_n; k++) begin
            check(rcv_i[k] == exp_i[k], {tag, " I sample"}, rcv_i[k], exp_i[k]);
            check(rcv_q[k] == exp_q[k], {tag, " Q sample"}, rcv_q[k], exp_q[k]);
        end
    endtask

    initial begin
        // R10: reset state
        apply_reset();
        repeat (3) @(negedge rd_clk);
        check(out_i == 0 && out_q == 0, "R10 outputs after reset", {out_i, out_q}, 0);
        check(!out_stb && !overflow && !underflow, "R10 strobe and flags after reset",
              {out_stb, overflow, underflow}, 0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int m = 0; m < 6; m++) begin
            {cfg_q_first, cfg_i_low, cfg_twos, cfg_ddr, cfg_ratio} = MODES[m];
            apply_reset();
            for (int k = 0; k < 6; k++) begin
                send_pair(12'(m * 37 + k * 291 + 11), 12'(m * 53 + k * 613 + 1234));
            end
            idle_bus();
            repeat (300) @(negedge rd_clk);
            compare_all($sformatf("R1 R2 R3 R4 mode %0d", m));
            for (int k = 1; k < 4 && k < rcv_n; k++) begin
                check(gap[k] == GAPS[m], $sformatf("R5 R6 spacing mode %0d", m),
                      gap[k], GAPS[m]);
            end
            check(!overflow, "R7 no overflow in table run", overflow, 0);
        end

        // R9: priming threshold, then R8 underflow once drained
        cfg_q_first = 0; cfg_i_low = 0; cfg_twos = 1; cfg_ddr = 0; cfg_ratio = 2'd0;
        apply_reset();
        for (int k = 0; k < 3; k++) send_pair(12'(100 + k), 12'(200 + k));
        idle_bus();
        repeat (80) @(negedge rd_clk);
        check(rcv_n == 0, "R9 no delivery below half depth", rcv_n, 0);
        check(!underflow, "R9 no underflow while priming", underflow, 0);
        send_pair(12'h7FF, 12'h800);
        idle_bus();
        repeat (80) @(negedge rd_clk);
        compare_all("R9 delivery after threshold");
        check(underflow, "R8 underflow after drain", underflow, 1);

        // R2: orphan trailing word dropped, repeated leading word replaces
        apply_reset();
        send_word(12'h111, 1'b0);
        send_word(12'h222, 1'b1);
        send_word(12'h333, 1'b1);
        exp_i[0] = 12'h333; exp_q[0] = 12'h444; exp_n = 1;
        send_word(12'h444, 1'b0);
        for (int k = 0; k < 3; k++) send_pair(12'(k + 5), 12'(k + 9));
        idle_bus();
        repeat (80) @(negedge rd_clk);
        compare_all("R2 replace and drop");

        // R7: overflow under back-to-back pairs at ratio 8
        cfg_ratio = 2'd3;
        apply_reset();
        for (int k = 0; k < 20; k++) send_pair(12'(k * 7 + 1), 12'(k * 11 + 3));
        idle_bus();
        repeat (400) @(negedge rd_clk);
        check(overflow, "R7 overflow set", overflow, 1);
        check(rcv_n < exp_n && rcv_n >= 8, "R7 pairs dropped", rcv_n, exp_n);
        begin
            int j = 0;
            for (int k = 0; k < rcv_n; k++) begin
                while (j < exp_n && !(rcv_i[k] == exp_i[j] && rcv_q[k] == exp_q[j])) j++;
                check(j < exp_n, "R7 delivered pairs in order", k, j);
                j++;
            end
        end
        apply_reset();
        repeat (3) @(negedge rd_clk);
        check(!overflow, "R7 overflow cleared by reset", overflow, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule